// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Controller

This block is a chipset configuration unit that software reaches through two byte-wide I/O ports. One port selects a register number. The other port reads or writes the selected register. The block holds 256 byte registers. A handful of them set, for each piece of the upper-memory area from C0000h to FFFFFh, whether reads and writes go to internal DRAM (shadow copy) or out to the external bus.

For any 20-bit memory address on its input, the block reports two routing flags: read-internal and write-internal. The flags are combinational from the address and the current register contents. A separate write-protect register can turn shadowed writes in selected regions back to the external bus. Three side outputs come from other registers:
- an external-cache enable level,
- a one-cycle wait-state update pulse,
- a one-cycle SMI request pulse.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: A write to I/O address 00A8h loads the low 8 data bits into the register index. A write to 00A9h stores the data byte into the register that the index selects, and leaves the index unchanged. While the I/O address is 00A9h, `io_rdata_o` shows the selected register.
- R2: While the I/O address is anything other than 00A9h (including 00A8h), `io_rdata_o` is FFh.
- R3: After reset every register and the index are zero. Every upper-memory address therefore routes both reads and writes externally (both route flags 0), and no pulse or cache-enable output is asserted.
- R4: Register 30h controls C0000h–CFFFFh in four 16 KB segments n = 0..3 (n = address bits 15:14). Bit 2n+1 set routes reads internally and bit 2n set routes writes internally. A cleared bit routes that access externally.
- R5: Register 31h controls D0000h–DFFFFh with the same segment and bit layout as register 30h.
- R6: Register 32h controls the 64 KB regions. Bit 7 is read and bit 6 is write for E0000h–EFFFFh. Bit 5 is read and bit 4 is write for F0000h–FFFFFh.
- R7: Register 40h write-protects regions:
  - bit 7 protects C0000h–C7FFFh,
  - bit 6 protects F0000h–FFFFFh,
  - bit 5 protects E0000h–EFFFFh.

  A protected region routes writes externally even when its write bit is set. Reads, C8000h–CFFFFh and all D segments are unaffected.
- R8: Addresses below C0000h always report internal routing for both reads and writes.
- R9: `xcache_en_o` is high exactly when register 50h has bit 7 or bit 2 set.
- R10: A data-port write to register 03h makes `ws_upd_o` high for the single cycle after the write edge. Writes to other registers, and index-port writes, make no pulse.
- R11: A data-port write to register 5Bh with data bit 5 set makes `smi_req_o` high for the single cycle after the write edge. The same write with bit 5 clear makes no pulse.
- R12: All 8 bits of every register are stored and read back exactly, and each register keeps its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_wr_i | input | 1 | I/O write strobe, one cycle per write |
| io_addr_i | input | 16 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data (combinational) |
| mem_addr_i | input | 20 | Memory address to classify |
| rd_int_o | output | 1 | Read of mem_addr_i is served internally |
| wr_int_o | output | 1 | Write of mem_addr_i is served internally |
| xcache_en_o | output | 1 | External cache enable |
| ws_upd_o | output | 1 | Wait-state update pulse |
| smi_req_o | output | 1 | SMI request pulse |

## Verification
The hardest situation to reach is the interaction between a set write bit and the protect register at the edges of the protected ranges. Examples are C7FFFh against C8000h, and E versus F, whose protect bits are not in address order. Each of these needs four register programmings through the two-step index/data sequence before a single address can be judged. A vector table drives each register combination through the ports, probes addresses on both sides of each boundary, and includes cases where the protect bit of the neighbouring region is set. The pulse outputs are checked in the single cycle after the write edge and again one cycle later. Index-only writes of the trigger value check that no pulse fires.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;

  // Register numbers whose contents drive outputs
  localparam byte_t REG_WAIT  = 8'h03;
  localparam byte_t REG_SEG_C = 8'h30;
  localparam byte_t REG_SEG_D = 8'h31;
  localparam byte_t REG_SEG_H = 8'h32;
  localparam byte_t REG_WPROT = 8'h40;
  localparam byte_t REG_CACHE = 8'h50;
  localparam byte_t REG_SMI   = 8'h5B;

  // Bit positions
  localparam int unsigned WP_C_BIT   = 7;
  localparam int unsigned WP_F_BIT   = 6;
  localparam int unsigned WP_E_BIT   = 5;
  localparam int unsigned E_RD_BIT   = 7;
  localparam int unsigned E_WR_BIT   = 6;
  localparam int unsigned F_RD_BIT   = 5;
  localparam int unsigned F_WR_BIT   = 4;
  localparam int unsigned CACHE_BIT0 = 7;
  localparam int unsigned CACHE_BIT1 = 2;
  localparam int unsigned SMI_BIT    = 5;
endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs #(
  parameter int unsigned NREGS = 256,
  parameter int unsigned DW    = 8,
  localparam int unsigned IW   = $clog2(NREGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      idx_we_i,
  input  logic                      dat_we_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [IW-1:0]             idx_o,
  output logic [NREGS-1:0][DW-1:0]  regs_o
);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (idx_we_i) idx_q <= wdata_i[IW-1:0];
  end

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_o[g] <= '0;
      else if (dat_we_i && idx_q == IW'(g))     regs_o[g] <= wdata_i;
    end
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/shadow_route_dec.sv
module shadow_route_dec
  import shadow_attr_pkg::*;
#(
  parameter int unsigned MAW = 20,
  localparam logic [MAW-1:0] UPPER_BASE = MAW'(3) << (MAW - 2)
) (
  input  logic [MAW-1:0] addr_i,
  input  byte_t          seg_c_i,
  input  byte_t          seg_d_i,
  input  byte_t          seg_h_i,
  input  byte_t          wprot_i,
  output logic           rd_int_o,
  output logic           wr_int_o
);
  logic [1:0] blk;   // 64 KB block within upper area: C,D,E,F
  logic [1:0] seg;   // 16 KB segment within C/D
  logic       in_upper;

  assign in_upper = addr_i >= UPPER_BASE;
  assign blk      = addr_i[MAW-3:MAW-4];
  assign seg      = addr_i[MAW-5:MAW-6];

  always_comb begin
    rd_int_o = 1'b1;
    wr_int_o = 1'b1;
    if (in_upper) begin
      unique case (blk)
        2'b00: begin
          rd_int_o = seg_c_i[{seg, 1'b1}];
          // protect covers the lower two segments only
          wr_int_o = seg_c_i[{seg, 1'b0}] & ~(wprot_i[WP_C_BIT] & ~seg[1]);
        end
        2'b01: begin
          rd_int_o = seg_d_i[{seg, 1'b1}];
          wr_int_o = seg_d_i[{seg, 1'b0}];
        end
        2'b10: begin
          rd_int_o = seg_h_i[E_RD_BIT];
          wr_int_o = seg_h_i[E_WR_BIT] & ~wprot_i[WP_E_BIT];
        end
        default: begin
          rd_int_o = seg_h_i[F_RD_BIT];
          wr_int_o = seg_h_i[F_WR_BIT] & ~wprot_i[WP_F_BIT];
        end
      endcase
    end
  end
endmodule

// File: rtl/shadow_evt_pulse.sv
module shadow_evt_pulse
  import shadow_attr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dat_we_i,
  input  byte_t idx_i,
  input  byte_t wdata_i,
  output logic  ws_upd_o,
  output logic  smi_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_upd_o  <= 1'b0;
      smi_req_o <= 1'b0;
    end else begin
      ws_upd_o  <= dat_we_i && (idx_i == REG_WAIT);
      smi_req_o <= dat_we_i && (idx_i == REG_SMI) && wdata_i[SMI_BIT];
    end
  end
endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
  import shadow_attr_pkg::*;
#(
  parameter int unsigned   IO_AW    = 16,
  parameter int unsigned   MAW      = 20,
  parameter int unsigned   NREGS    = 256,
  parameter logic [15:0]   IDX_PORT = 16'h00A8,
  parameter logic [15:0]   DAT_PORT = 16'h00A9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             io_wr_i,
  input  logic [IO_AW-1:0] io_addr_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  input  logic [MAW-1:0]   mem_addr_i,
  output logic             rd_int_o,
  output logic             wr_int_o,
  output logic             xcache_en_o,
  output logic             ws_upd_o,
  output logic             smi_req_o
);
  localparam int unsigned IW = $clog2(NREGS);

  logic                         hit_idx, hit_dat;
  logic [IW-1:0]                idx;
  logic [NREGS-1:0][DATA_W-1:0] regs;
  byte_t                        idx_b;

  assign hit_idx = io_addr_i == IO_AW'(IDX_PORT);
  assign hit_dat = io_addr_i == IO_AW'(DAT_PORT);
  assign idx_b   = DATA_W'(idx);

  shadow_cfg_regs #(.NREGS(NREGS), .DW(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_we_i (io_wr_i & hit_idx),
    .dat_we_i (io_wr_i & hit_dat),
    .wdata_i  (io_wdata_i),
    .idx_o    (idx),
    .regs_o   (regs)
  );

  shadow_route_dec #(.MAW(MAW)) u_dec (
    .addr_i   (mem_addr_i),
    .seg_c_i  (regs[REG_SEG_C]),
    .seg_d_i  (regs[REG_SEG_D]),
    .seg_h_i  (regs[REG_SEG_H]),
    .wprot_i  (regs[REG_WPROT]),
    .rd_int_o (rd_int_o),
    .wr_int_o (wr_int_o)
  );

  shadow_evt_pulse u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dat_we_i  (io_wr_i & hit_dat),
    .idx_i     (idx_b),
    .wdata_i   (io_wdata_i),
    .ws_upd_o  (ws_upd_o),
    .smi_req_o (smi_req_o)
  );

  assign io_rdata_o  = hit_dat ? regs[idx] : 8'hFF;
  assign xcache_en_o = regs[REG_CACHE][CACHE_BIT0] | regs[REG_CACHE][CACHE_BIT1];
endmodule

// File: rtl/shadow_attr_ctrl_chk.sv
module shadow_attr_ctrl_chk #(
  parameter int unsigned IO_AW    = 16,
  parameter int unsigned MAW      = 20,
  parameter logic [15:0] IDX_PORT = 16'h00A8,
  parameter logic [15:0] DAT_PORT = 16'h00A9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             io_wr_i,
  input logic [IO_AW-1:0] io_addr_i,
  input logic [7:0]       io_wdata_i,
  input logic [7:0]       io_rdata_o,
  input logic [MAW-1:0]   mem_addr_i,
  input logic             rd_int_o,
  input logic             wr_int_o,
  input logic             ws_upd_o,
  input logic             smi_req_o
);
  localparam logic [MAW-1:0] UPPER = MAW'(3) << (MAW - 2);

  assert_rdata_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_addr_i != IO_AW'(DAT_PORT)) |-> (io_rdata_o == 8'hFF));

  assert_low_internal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_i < UPPER) |-> (rd_int_o && wr_int_o));

  assert_readback_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == IO_AW'(DAT_PORT)) |=>
      (io_addr_i != IO_AW'(DAT_PORT) || io_rdata_o == $past(io_wdata_i)));

  assert_ws_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ws_upd_o |-> $past(io_wr_i && io_addr_i == IO_AW'(DAT_PORT)));

  assert_smi_source_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o |-> $past(io_wr_i && io_addr_i == IO_AW'(DAT_PORT) && io_wdata_i[5]));

  assert_idx_write_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i == IO_AW'(IDX_PORT)) |=> !ws_upd_o && !smi_req_o);
endmodule

bind shadow_attr_ctrl shadow_attr_ctrl_chk #(
  .IO_AW(IO_AW), .MAW(MAW), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_wr_i    (io_wr_i),
  .io_addr_i  (io_addr_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .mem_addr_i (mem_addr_i),
  .rd_int_o   (rd_int_o),
  .wr_int_o   (wr_int_o),
  .ws_upd_o   (ws_upd_o),
  .smi_req_o  (smi_req_o)
);

// File: tb/shadow_attr_ctrl_tb.sv
module shadow_attr_ctrl_tb;
  localparam logic [15:0] IDXP = 16'h00A8;
  localparam logic [15:0] DATP = 16'h00A9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [19:0] mem_addr = '0;
  logic        rd_int, wr_int, xcache_en, ws_upd, smi_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  shadow_attr_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_wr_i(io_wr), .io_addr_i(io_addr),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .mem_addr_i(mem_addr),
    .rd_int_o(rd_int), .wr_int_o(wr_int), .xcache_en_o(xcache_en),
    .ws_upd_o(ws_upd), .smi_req_o(smi_req)
  );

  typedef struct packed {
    logic [7:0]  r30, r31, r32, r40;
    logic [19:0] addr;
    logic        rd, wr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{8'h02, 8'h00, 8'h00, 8'h00, 20'hC1234, 1'b1, 1'b0}, // R4 seg0 read
    '{8'h01, 8'h00, 8'h00, 8'h00, 20'hC0000, 1'b0, 1'b1}, // R4 seg0 write
    '{8'h01, 8'h00, 8'h00, 8'h80, 20'hC3FFF, 1'b0, 1'b0}, // R7 C protect
    '{8'h04, 8'h00, 8'h00, 8'h80, 20'hC4000, 1'b0, 1'b0}, // R7 seg1 protect
    '{8'h0C, 8'h00, 8'h00, 8'h00, 20'hC7FFF, 1'b1, 1'b1}, // R4 seg1
    '{8'h0C, 8'h00, 8'h00, 8'h80, 20'hC7FFF, 1'b1, 1'b0}, // R7 read unaffected
    '{8'h30, 8'h00, 8'h00, 8'h80, 20'hC8000, 1'b1, 1'b1}, // R7 seg2 not protected
    '{8'hC0, 8'h00, 8'h00, 8'h80, 20'hCFFFF, 1'b1, 1'b1}, // R4 seg3
    '{8'hFF, 8'h00, 8'h00, 8'h00, 20'hD0000, 1'b0, 1'b0}, // R5 D independent of 30h
    '{8'h00, 8'h80, 8'h00, 8'h00, 20'hDC000, 1'b1, 1'b0}, // R5 seg3 read
    '{8'h00, 8'h04, 8'h00, 8'hE0, 20'hD4000, 1'b0, 1'b1}, // R7 D ignores protect
    '{8'h00, 8'h00, 8'hC0, 8'h00, 20'hE8000, 1'b1, 1'b1}, // R6 E
    '{8'h00, 8'h00, 8'hC0, 8'h20, 20'hE8000, 1'b1, 1'b0}, // R7 E protect
    '{8'h00, 8'h00, 8'hC0, 8'h40, 20'hEFFFF, 1'b1, 1'b1}, // R7 F bit spares E
    '{8'h00, 8'h00, 8'h30, 8'h40, 20'hF0000, 1'b1, 1'b0}, // R7 F protect
    '{8'h00, 8'h00, 8'h10, 8'h20, 20'hFFFFF, 1'b0, 1'b1}, // R6 F write
    '{8'hFF, 8'hFF, 8'hFF, 8'hE0, 20'hBFFFF, 1'b1, 1'b1}, // R8 below upper
    '{8'h00, 8'h00, 8'h00, 8'h00, 20'h00000, 1'b1, 1'b1}  // R8 low
  };

  task automatic check(input logic ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_addr = 16'h0000;
  endtask

  task automatic set_reg(input logic [7:0] r, input logic [7:0] v);
    io_write(IDXP, r);
    io_write(DATP, v);
  endtask

  task automatic read_reg(input logic [7:0] r, output logic [7:0] v);
    io_write(IDXP, r);
    io_addr = DATP;
    #1 v = io_rdata;
    io_addr = 16'h0000;
  endtask

  logic done = 1'b0;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset state
    io_addr = DATP; #1;
    check(io_rdata == 8'h00, "R3 reg0 after reset", io_rdata, 8'h00);
    io_addr = 16'h0000;
    mem_addr = 20'hC0000; #1;
    check({rd_int, wr_int} == 2'b00, "R3 C0000 route", {rd_int, wr_int}, 2'b00);
    mem_addr = 20'hF8000; #1;
    check({rd_int, wr_int} == 2'b00, "R3 F8000 route", {rd_int, wr_int}, 2'b00);
    check({xcache_en, ws_upd, smi_req} == 3'b000, "R3 side outputs",
          {xcache_en, ws_upd, smi_req}, 3'b000);
    read_reg(8'h32, rv);
    check(rv == 8'h00, "R3 reg32 after reset", rv, 8'h00);

    // R2 non-data ports
    io_addr = 16'h0080; #1;
    check(io_rdata == 8'hFF, "R2 other port", io_rdata, 8'hFF);
    io_addr = IDXP; #1;
    check(io_rdata == 8'hFF, "R2 index port", io_rdata, 8'hFF);
    io_addr = 16'h01A9; #1;
    check(io_rdata == 8'hFF, "R2 alias port", io_rdata, 8'hFF);
    io_addr = 16'h0000;

    // R1 / R12 storage and readback
    set_reg(8'h77, 8'hA5);
    set_reg(8'h12, 8'h5A);
    set_reg(8'hFF, 8'h3C);
    read_reg(8'h77, rv);
    check(rv == 8'hA5, "R1 reg77 readback", rv, 8'hA5);
    read_reg(8'h12, rv);
    check(rv == 8'h5A, "R12 reg12 readback", rv, 8'h5A);
    read_reg(8'hFF, rv);
    check(rv == 8'h3C, "R12 regFF readback", rv, 8'h3C);
    set_reg(8'h00, 8'hFF);
    read_reg(8'h00, rv);
    check(rv == 8'hFF, "R12 all bits kept", rv, 8'hFF);
    // R1 index unchanged by a data write
    io_write(IDXP, 8'h12);
    io_write(DATP, 8'h81);
    io_write(DATP, 8'h42);
    io_addr = DATP; #1;
    check(io_rdata == 8'h42, "R1 index held across data writes", io_rdata, 8'h42);
    io_addr = 16'h0000;

    // R4..R8 route table
    for (int i = 0; i < NV; i++) begin
      set_reg(8'h30, VECS[i].r30);
      set_reg(8'h31, VECS[i].r31);
      set_reg(8'h32, VECS[i].r32);
      set_reg(8'h40, VECS[i].r40);
      mem_addr = VECS[i].addr; #1;
      check({rd_int, wr_int} == {VECS[i].rd, VECS[i].wr},
            $sformatf("R4/R5/R6/R7/R8 route vec %0d", i),
            {rd_int, wr_int}, {VECS[i].rd, VECS[i].wr});
    end

    // R9 cache enable
    set_reg(8'h50, 8'h80); #1;
    check(xcache_en == 1'b1, "R9 bit7", xcache_en, 1'b1);
    set_reg(8'h50, 8'h04); #1;
    check(xcache_en == 1'b1, "R9 bit2", xcache_en, 1'b1);
    set_reg(8'h50, 8'h7B); #1;
    check(xcache_en == 1'b0, "R9 other bits", xcache_en, 1'b0);

    // R10 wait-state pulse
    set_reg(8'h03, 8'h00);
    check(ws_upd == 1'b1, "R10 pulse high", ws_upd, 1'b1);
    @(negedge clk);
    check(ws_upd == 1'b0, "R10 pulse one cycle", ws_upd, 1'b0);
    io_write(IDXP, 8'h03);
    check(ws_upd == 1'b0, "R10 index write quiet", ws_upd, 1'b0);
    set_reg(8'h04, 8'h00);
    check(ws_upd == 1'b0, "R10 other reg quiet", ws_upd, 1'b0);

    // R11 SMI pulse
    set_reg(8'h5B, 8'h20);
    check(smi_req == 1'b1, "R11 pulse high", smi_req, 1'b1);
    @(negedge clk);
    check(smi_req == 1'b0, "R11 pulse one cycle", smi_req, 1'b0);
    set_reg(8'h5B, 8'hDF);
    check(smi_req == 1'b0, "R11 bit5 clear quiet", smi_req, 1'b0);
    set_reg(8'h5A, 8'hFF);
    check(smi_req == 1'b0, "R11 other reg quiet", smi_req, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule